// File: doc/BRIEF.md
# Display Init Sequence Player

This block brings up a small display controller after power-on. It steps through a byte-coded start-up table that is fixed at build time. It turns the table into write cycles on an 8-bit parallel bus of the 8080 kind, which has a chip select, a data/command select, an active-low write strobe and a data byte. An entry in the table is a command byte, then a byte that counts its parameters, then the parameter bytes. One reserved byte value acts as an escape that means "pause", and the byte after it gives the pause length in milliseconds.

A controller pulses `start` once. The player raises `busy` and issues every write in table order, with the programmed pauses. When it has consumed the last table byte, it drops `busy` and holds `done` high until the next `start`. Reading from the panel and streaming pixels are not part of this block.

Top module: `init_seq_player`

## Requirements
- R1: When a non-escape byte is decoded, it is written as a command with `dc` = 0. The next byte is read as a parameter count N, and the following N bytes are written in table order with `dc` = 1. A new write burst (falling `cs_n`) always begins with a command.
- R2: An entry whose count is 0 produces exactly one write, the command itself. This holds also when that count byte is the last byte of the table.
- R3: The escape byte (parameter `ESC`, default 0xDD) followed by a value M keeps the bus idle for exactly M × `CLKS_PER_MS` cycles plus the decode cycles. Neither of the two bytes is written. When M = 0, no waiting cycles are added.
- R4: An escape in the final table position is treated as a zero-length pause, and playback then finishes.
- R5: Nothing is fetched beyond `LEN` bytes. If a count asks for more parameters than the table still holds, only the bytes present are written and the player finishes.
- R6: Each write holds `wr_n` low for `STROBE_CYCLES` cycles with `cs_n` low, followed by one cycle with `wr_n` high and `cs_n` still low. `data` and `dc` do not change during the low phase or the high cycle that follows it.
- R7: `start` is sampled only while idle. On the next cycle `busy` is 1 and `done` is 0. A `start` seen while `busy` is high has no effect.
- R8: After the last byte, `busy` falls and `done` rises in the same cycle. `done` stays high until a new `start` is accepted, and it is never high together with `busy`.
- R9: During reset, `busy` = 0, `done` = 0, `cs_n` = 1 and `wr_n` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin playback (sampled while idle) |
| busy | output | 1 | Playback in progress |
| done | output | 1 | Playback finished; held until next start |
| cs_n | output | 1 | Bus chip select, active low |
| dc | output | 1 | Data/command select: 0 command, 1 parameter |
| wr_n | output | 1 | Write strobe, active low |
| data | output | 8 | Bus data byte |

## Verification
The embedded properties assume that `start` is a synchronous level that changes only away from the clock edge, and that reset is applied once before any `start`. The bench drives `start` on the falling edge in single-cycle pulses. It includes one pulse in the middle of a run to exercise the ignore rule. It also assumes well-formed parameter values, such as a strobe length of at least one cycle and a non-zero clock count per millisecond. For that reason every instance is built with small but legal values (3 cycles per millisecond, 2-cycle strobe). Four tables are played side by side: the typical power-up table, one ending in a zero count after a zero pause, one ending in a lone escape, and one whose count overruns the end.

// File: rtl/init_seq_player.sv
module init_seq_player #(
  parameter int          LEN           = 25,
  parameter logic [8*LEN-1:0] TABLE    = {8'h3A, 8'h01, 8'h55,
                                          8'h11, 8'h00,
                                          8'hDD, 8'd150,
                                          8'h2A, 8'h04, 8'h00, 8'h00, 8'h01, 8'h3F,
                                          8'h2B, 8'h04, 8'h00, 8'h00, 8'h01, 8'hDF,
                                          8'hDD, 8'd100,
                                          8'h29, 8'h00,
                                          8'hDD, 8'd30},
  parameter int          CLKS_PER_MS   = 50000,
  parameter int          STROBE_CYCLES = 2,
  parameter logic [7:0]  ESC           = 8'hDD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic       cs_n,
  output logic       dc,
  output logic       wr_n,
  output logic [7:0] data
);
  localparam int PW = $clog2(LEN + 3);
  localparam int TW = $clog2(CLKS_PER_MS + 1);
  localparam int SW = $clog2(STROBE_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_LOW, S_GAP, S_WAIT} st_t;

  st_t           st;
  logic [PW-1:0] ptr;
  logic [7:0]    left;
  logic [7:0]    ms_left;
  logic [TW-1:0] tick;
  logic [SW-1:0] lo_cnt;

  function automatic logic [7:0] rom(input int idx);
    return (idx < LEN) ? TABLE[8*(LEN-1-idx) +: 8] : 8'h00;
  endfunction

  logic [7:0] cur, nxt;
  logic       has_nxt, at_end;
  assign cur     = rom(int'(ptr));
  assign nxt     = rom(int'(ptr) + 1);
  assign has_nxt = (int'(ptr) + 1) < LEN;
  assign at_end  = int'(ptr) >= LEN;

  assign busy = (st != S_IDLE);
  assign wr_n = (st != S_LOW);
  assign cs_n = !(st == S_LOW || st == S_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      done    <= 1'b0;
      ptr     <= '0;
      left    <= '0;
      ms_left <= '0;
      tick    <= '0;
      lo_cnt  <= '0;
      data    <= '0;
      dc      <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st   <= S_DEC;
          done <= 1'b0;
          ptr  <= '0;
        end
        S_DEC: begin
          if (at_end) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else if (cur == ESC) begin
            ptr     <= ptr + PW'(2);
            ms_left <= has_nxt ? nxt : 8'h00;
            tick    <= '0;
            if (has_nxt && nxt != 8'h00) st <= S_WAIT;
          end else begin
            data   <= cur;
            dc     <= 1'b0;
            left   <= has_nxt ? nxt : 8'h00;
            ptr    <= ptr + PW'(2);
            lo_cnt <= '0;
            st     <= S_LOW;
          end
        end
        S_LOW: begin
          lo_cnt <= lo_cnt + SW'(1);
          if (lo_cnt == SW'(STROBE_CYCLES - 1)) st <= S_GAP;
        end
        S_GAP: begin
          if (left != 8'h00 && !at_end) begin
            data   <= cur;
            dc     <= 1'b1;
            ptr    <= ptr + PW'(1);
            left   <= left - 8'h01;
            lo_cnt <= '0;
            st     <= S_LOW;
          end else begin
            st <= S_DEC;
          end
        end
        S_WAIT: begin
          if (tick == TW'(CLKS_PER_MS - 1)) begin
            tick    <= '0;
            ms_left <= ms_left - 8'h01;
            if (ms_left == 8'h01) st <= S_DEC;
          end else begin
            tick <= tick + TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_burst_opens_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !dc);

  a_r6_bus_held_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(wr_n)) |-> ($stable(data) && $stable(dc)));

  a_r5_fetch_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) <= LEN + 1);

  a_r7_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !done));

  a_r8_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/init_seq_model.sv
module init_seq_model #(
  parameter int               LEN   = 1,
  parameter logic [8*LEN-1:0] TABLE = '0,
  parameter int               CPM   = 1,
  parameter int               WRC   = 1,
  parameter logic [7:0]       ESC   = 8'hDD
) (
  input  logic       clk,
  input  logic       start,
  output logic       e_busy,
  output logic       e_done,
  output logic       e_cs_n,
  output logic       e_wr_n,
  output logic       e_dc,
  output logic [7:0] e_data
);
  byte unsigned q[$];

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [7:0] b, input logic d);
    for (int c = 0; c < WRC; c++) begin
      step();
      e_cs_n = 1'b0; e_wr_n = 1'b0; e_data = b; e_dc = d;
    end
    step();
    e_wr_n = 1'b1;
  endtask

  task automatic play();
    int i, n, cnt;
    #1;
    e_busy = 1'b1;
    e_done = 1'b0;
    i = 0;
    while (i < q.size()) begin
      if (q[i] == ESC) begin
        n = (i + 1 < q.size()) ? int'(q[i+1]) : 0;
        i += 2;
        repeat (n * CPM + 1) step();
      end else begin
        cnt = (i + 1 < q.size()) ? int'(q[i+1]) : 0;
        put(q[i], 1'b0);
        i += 2;
        while (cnt > 0 && i < q.size()) begin
          put(q[i], 1'b1);
          i++;
          cnt--;
        end
        step();
        e_cs_n = 1'b1;
        e_wr_n = 1'b1;
      end
    end
    step();
    e_busy = 1'b0;
    e_done = 1'b1;
  endtask

  initial begin
    for (int j = 0; j < LEN; j++) q.push_back(TABLE[8*(LEN-1-j) +: 8]);
    e_busy = 1'b0; e_done = 1'b0; e_cs_n = 1'b1; e_wr_n = 1'b1; e_dc = 1'b0; e_data = 8'h00;
    forever begin
      @(posedge clk);
      if (start && !e_busy) play();
    end
  end
endmodule

// File: tb/init_seq_player_test.sv
module init_seq_player_test;
  localparam int CPM = 3;
  localparam int WRC = 2;

  localparam int L0 = 25;
  localparam logic [8*L0-1:0] T0 = {8'h3A, 8'h01, 8'h55, 8'h11, 8'h00, 8'hDD, 8'd150,
                                    8'h2A, 8'h04, 8'h00, 8'h00, 8'h01, 8'h3F,
                                    8'h2B, 8'h04, 8'h00, 8'h00, 8'h01, 8'hDF,
                                    8'hDD, 8'd100, 8'h29, 8'h00, 8'hDD, 8'd30};
  localparam int L1 = 8;
  localparam logic [8*L1-1:0] T1 = {8'h2A, 8'h02, 8'hAB, 8'hCD, 8'hDD, 8'h00, 8'h29, 8'h00};
  localparam int L2 = 3;
  localparam logic [8*L2-1:0] T2 = {8'h11, 8'h00, 8'hDD};
  localparam int L3 = 5;
  localparam logic [8*L3-1:0] T3 = {8'h29, 8'h00, 8'h2C, 8'h05, 8'h12};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] bsy, dn, csn, wrn, dcs;
  logic [3:0] ebsy, edn, ecsn, ewrn, edcs;
  logic [7:0] dat [4];
  logic [7:0] edat [4];

  init_seq_player #(.LEN(L0), .TABLE(T0), .CLKS_PER_MS(CPM), .STROBE_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(bsy[0]), .done(dn[0]),
    .cs_n(csn[0]), .dc(dcs[0]), .wr_n(wrn[0]), .data(dat[0]));
  init_seq_player #(.LEN(L1), .TABLE(T1), .CLKS_PER_MS(CPM), .STROBE_CYCLES(WRC)) uut_b (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(bsy[1]), .done(dn[1]),
    .cs_n(csn[1]), .dc(dcs[1]), .wr_n(wrn[1]), .data(dat[1]));
  init_seq_player #(.LEN(L2), .TABLE(T2), .CLKS_PER_MS(CPM), .STROBE_CYCLES(WRC)) uut_c (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(bsy[2]), .done(dn[2]),
    .cs_n(csn[2]), .dc(dcs[2]), .wr_n(wrn[2]), .data(dat[2]));
  init_seq_player #(.LEN(L3), .TABLE(T3), .CLKS_PER_MS(CPM), .STROBE_CYCLES(WRC)) uut_d (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(bsy[3]), .done(dn[3]),
    .cs_n(csn[3]), .dc(dcs[3]), .wr_n(wrn[3]), .data(dat[3]));

  init_seq_model #(.LEN(L0), .TABLE(T0), .CPM(CPM), .WRC(WRC)) m0 (.clk(clk), .start(start),
    .e_busy(ebsy[0]), .e_done(edn[0]), .e_cs_n(ecsn[0]), .e_wr_n(ewrn[0]), .e_dc(edcs[0]), .e_data(edat[0]));
  init_seq_model #(.LEN(L1), .TABLE(T1), .CPM(CPM), .WRC(WRC)) m1 (.clk(clk), .start(start),
    .e_busy(ebsy[1]), .e_done(edn[1]), .e_cs_n(ecsn[1]), .e_wr_n(ewrn[1]), .e_dc(edcs[1]), .e_data(edat[1]));
  init_seq_model #(.LEN(L2), .TABLE(T2), .CPM(CPM), .WRC(WRC)) m2 (.clk(clk), .start(start),
    .e_busy(ebsy[2]), .e_done(edn[2]), .e_cs_n(ecsn[2]), .e_wr_n(ewrn[2]), .e_dc(edcs[2]), .e_data(edat[2]));
  init_seq_model #(.LEN(L3), .TABLE(T3), .CPM(CPM), .WRC(WRC)) m3 (.clk(clk), .start(start),
    .e_busy(ebsy[3]), .e_done(edn[3]), .e_cs_n(ecsn[3]), .e_wr_n(ewrn[3]), .e_dc(edcs[3]), .e_data(edat[3]));

  int checks = 0, errors = 0;
  bit ended = 0;

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // cycle-by-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      for (int k = 0; k < 4; k++) begin
        string dtag;
        dtag = (k == 0) ? "R1" : (k == 1) ? "R2" : (k == 2) ? "R4" : "R5";
        chk("R7", $sformatf("busy[%0d]", k), {7'd0, bsy[k]}, {7'd0, ebsy[k]});
        chk("R8", $sformatf("done[%0d]", k), {7'd0, dn[k]},  {7'd0, edn[k]});
        chk("R6", $sformatf("cs_n[%0d]", k), {7'd0, csn[k]}, {7'd0, ecsn[k]});
        chk("R6", $sformatf("wr_n[%0d]", k), {7'd0, wrn[k]}, {7'd0, ewrn[k]});
        if (!ecsn[k]) begin
          chk(dtag, $sformatf("dc[%0d]", k),   {7'd0, dcs[k]}, {7'd0, edcs[k]});
          chk(dtag, $sformatf("data[%0d]", k), dat[k], edat[k]);
        end
      end
    end
  end

  // first-run statistics on the typical table
  bit   run1 = 0;
  int   cs_falls = 0, wr_falls = 0, idle_run = 0, idle_max = 0;
  logic pcs = 1'b1, pwr = 1'b1;
  always @(negedge clk) begin
    if (run1) begin
      if (pcs && !csn[0]) cs_falls++;
      if (pwr && !wrn[0]) wr_falls++;
      if (bsy[0] && csn[0]) begin
        idle_run++;
        if (idle_run > idle_max) idle_max = idle_run;
      end else idle_run = 0;
    end
    pcs = csn[0];
    pwr = wrn[0];
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk("R9", "reset busy", {7'd0, bsy[k]}, 8'd0);
      chk("R9", "reset done", {7'd0, dn[k]},  8'd0);
      chk("R9", "reset cs_n", {7'd0, csn[k]}, 8'd1);
      chk("R9", "reset wr_n", {7'd0, wrn[k]}, 8'd1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b1; run1 = 1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "busy after start", {7'd0, bsy[0]}, 8'd1);
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "start ignored while busy", {7'd0, bsy[0]}, 8'd1);
    while (dn != 4'hF) @(negedge clk);
    run1 = 0;
    chk("R2", "command bursts in typical table", 8'(cs_falls), 8'd5);
    chk("R1", "total writes in typical table", 8'(wr_falls), 8'd14);
    chk("R3", "longest idle span (150 ms pause)", 8'(idle_max - 400), 8'(452 - 400));
    repeat (10) @(negedge clk);
    chk("R8", "done held while idle", {7'd0, dn[0]}, 8'd1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "restart busy", {7'd0, bsy[0]}, 8'd1);
    chk("R8", "restart clears done", {7'd0, dn[0]}, 8'd0);
    while (dn != 4'hF) @(negedge clk);
    repeat (5) @(negedge clk);
    wrap_up();
  end
endmodule